// File: doc/BRIEF.md
# Panel Command Bus Bridge

This block lets host software run single command cycles against an LCD module that hangs on an 8080-style parallel bus. Software loads a 32-bit command word whose upper control bits mark it as a bus cycle and pick index or data. A write to a trigger register then launches the cycle toward one of two panels, main or sub. Reads work the same way: software prepares the read word, fires the read trigger, waits for the busy flag to clear, and then takes the returned value from the low half of the read word.

Internally a small register file decodes host writes into launch requests. A sequencer then drives the chip selects, the write or read strobe and the register-select line. Strobe low and high widths are parameters in clock cycles. Register select and chip select are set up one cycle before the strobe falls and held for the whole high phase after it rises.

Top module: `panel_cmd_bridge`

## Requirements
- R1: During and right after reset, both chip selects (`bus_cs_n`) and both strobes are high, the data bus is not driven, and the status word reads 0.
- R2: With bit 28 set and bit 24 clear in the command word, a write trigger produces an index cycle: register select low, and the command word's low DW bits are driven on `bus_dout` with `bus_oe` high.
- R3: With bits 28 and 24 both set in the command word, a write trigger produces a data cycle with register select high.
- R4: A trigger register write (offset 2 for write, offset 3 for read) launches a cycle only when its bit 0 is 1. Its bit 1 picks the panel: 0 drives `bus_cs_n[0]` (main) low and 1 drives `bus_cs_n[1]` (sub) low.
- R5: Status bit 1 (offset 4) reads 1 from the cycle after an accepted trigger until the sequence ends, which is 1 + LOW_CYC + HIGH_CYC cycles.
- R6: A read trigger produces a read-strobe cycle with the data bus released (`bus_oe` low). Register select follows bit 24 of the read word (offset 1).
- R7: Bus data is captured on the rising edge of the read strobe. It is returned in bits 15:0 of the read word, and bits 31:16 keep their written value.
- R8: Each strobe stays low for exactly LOW_CYC cycles. Chip select is active in the cycle before the fall and stays active for HIGH_CYC cycles after the rise. Register select is stable while chip select is active.
- R9: A trigger written while busy is ignored, and the running cycle completes unchanged.
- R10: A write trigger is ignored when bit 28 of the command word (offset 0) is clear.
- R11: At most one chip select is active at a time, and the write and read strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write enable |
| host_addr | input | 3 | Register offset: 0 command, 1 read word, 2 write trigger, 3 read trigger, 4 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data for host_addr (combinational) |
| bus_cs_n | output | 2 | Active-low chip selects: [0] main, [1] sub |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_rs | output | 1 | Register select: 0 index, 1 data |
| bus_dout | output | DW | Bus data driven during write cycles |
| bus_oe | output | 1 | Output enable for bus_dout |
| bus_din | input | DW | Bus data returned by the panel |

## Verification
A sequencer stuck in a wrong state shows up at once on the ports. Within one cycle of the error, a strobe falls without chip-select setup, or the busy flag stays high past 1 + LOW_CYC + HIGH_CYC cycles. A wrong width counter changes the measured low or high phase length, and the bench measures that length on every cycle. Wrong latched panel, register-select or data state shows up at the strobe's rising edge, where each finished cycle is compared with the expected item. A wrong capture point shows up in the read word on the first poll after busy clears.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   localparam int ADDR_W = 3;
   localparam int NSEL   = 2;
   localparam int SEL_W  = 1;

   localparam logic [ADDR_W-1:0] A_CMD    = 3'd0;
   localparam logic [ADDR_W-1:0] A_RDW    = 3'd1;
   localparam logic [ADDR_W-1:0] A_WTRIG  = 3'd2;
   localparam logic [ADDR_W-1:0] A_RTRIG  = 3'd3;
   localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

   localparam int BIT_CYCLE = 28;
   localparam int BIT_DATA  = 24;
   localparam int BIT_GO    = 0;
   localparam int BIT_PANEL = 1;
   localparam int BIT_BUSY  = 1;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_SETUP = 2'd1,
      S_LOW   = 2'd2,
      S_HIGH  = 2'd3
   } seq_state_t;
endpackage

// File: rtl/pcb_regs.sv
module pcb_regs
   import pcb_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              busy,
   input  logic              cap_en,
   input  logic [DW-1:0]     cap_data,
   output logic              go_wr,
   output logic              go_rd,
   output logic [SEL_W-1:0]  go_sel,
   output logic              go_rs,
   output logic [DW-1:0]     go_dat
);
   logic [31:0] cmd_q;
   logic [31:0] rdw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         rdw_q <= '0;
      end else begin
         if (we && addr == A_CMD)
            cmd_q <= wdata;
         if (we && addr == A_RDW)
            rdw_q <= wdata;
         else if (cap_en)
            rdw_q[15:0] <= 16'(cap_data);
      end
   end

   always_comb begin
      go_wr  = we && (addr == A_WTRIG) && wdata[BIT_GO] && cmd_q[BIT_CYCLE] && !busy;
      go_rd  = we && (addr == A_RTRIG) && wdata[BIT_GO] && !busy;
      go_sel = wdata[BIT_PANEL +: SEL_W];
      go_rs  = go_rd ? rdw_q[BIT_DATA] : cmd_q[BIT_DATA];
      go_dat = cmd_q[DW-1:0];
   end

   always_comb begin
      unique case (addr)
         A_CMD:    rdata = cmd_q;
         A_RDW:    rdata = rdw_q;
         A_STATUS: rdata = 32'(busy) << BIT_BUSY;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/pcb_seq.sv
module pcb_seq
   import pcb_pkg::*;
#(
   parameter int DW       = 16,
   parameter int LOW_CYC  = 2,
   parameter int HIGH_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_wr,
   input  logic             go_rd,
   input  logic [SEL_W-1:0] go_sel,
   input  logic             go_rs,
   input  logic [DW-1:0]    go_dat,
   output logic             busy,
   output logic             cap_en,
   output logic [DW-1:0]    cap_data,
   output logic [NSEL-1:0]  cs_n,
   output logic             wr_n,
   output logic             rd_n,
   output logic             rs,
   output logic [DW-1:0]    dout,
   output logic             oe,
   input  logic [DW-1:0]    din
);
   localparam int MAXW = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
   localparam int CW   = (MAXW > 1) ? $clog2(MAXW) : 1;
   localparam logic [CW-1:0] LOW_M1  = CW'(LOW_CYC - 1);
   localparam logic [CW-1:0] HIGH_M1 = CW'(HIGH_CYC - 1);

   seq_state_t       state_q;
   logic [CW-1:0]    cnt_q;
   logic             rd_q, rs_q;
   logic [SEL_W-1:0] sel_q;
   logic [DW-1:0]    dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cnt_q   <= '0;
         rd_q    <= 1'b0;
         rs_q    <= 1'b0;
         sel_q   <= '0;
         dat_q   <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: if (go_wr || go_rd) begin
               state_q <= S_SETUP;
               rd_q    <= go_rd;
               rs_q    <= go_rs;
               sel_q   <= go_sel;
               dat_q   <= go_dat;
            end
            S_SETUP: begin
               state_q <= S_LOW;
               cnt_q   <= LOW_M1;
            end
            S_LOW: if (cnt_q == '0) begin
               state_q <= S_HIGH;
               cnt_q   <= HIGH_M1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            S_HIGH: if (cnt_q == '0) state_q <= S_IDLE;
                    else cnt_q <= cnt_q - 1'b1;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   logic active;
   assign active   = (state_q != S_IDLE);
   assign busy     = active;
   assign wr_n     = !(state_q == S_LOW && !rd_q);
   assign rd_n     = !(state_q == S_LOW && rd_q);
   assign rs       = rs_q;
   assign dout     = dat_q;
   assign oe       = active && !rd_q;
   assign cap_en   = (state_q == S_LOW) && (cnt_q == '0) && rd_q;
   assign cap_data = din;

   for (genvar g = 0; g < NSEL; g++) begin : g_cs
      assign cs_n[g] = !(active && sel_q == SEL_W'(g));
   end

   // R11
   a_r11_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!wr_n && !rd_n));
   // R8
   a_r8_setup: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(wr_n) || $fell(rd_n)) |-> $past(cs_n != '1));
   a_r8_rs_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n != '1 && $past(cs_n != '1)) |-> $stable(rs));
   // R5
   a_r5_busy_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n || !rd_n) |-> busy);
   a_r5_go_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ((go_wr || go_rd) && !busy) |=> busy);
   // R6
   a_r6_released: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !oe);
endmodule

// File: rtl/panel_cmd_bridge.sv
module panel_cmd_bridge
   import pcb_pkg::*;
#(
   parameter int DW       = 16,
   parameter int LOW_CYC  = 2,
   parameter int HIGH_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic [NSEL-1:0]   bus_cs_n,
   output logic              bus_wr_n,
   output logic              bus_rd_n,
   output logic              bus_rs,
   output logic [DW-1:0]     bus_dout,
   output logic              bus_oe,
   input  logic [DW-1:0]     bus_din
);
   if (LOW_CYC < 1 || HIGH_CYC < 1) begin : g_bad_width
      $error("strobe widths must be at least one cycle");
   end
   if (DW < 8 || DW > 16) begin : g_bad_dw
      $error("bus width must lie between 8 and 16");
   end

   logic             busy, cap_en, go_wr, go_rd, go_rs;
   logic [DW-1:0]    cap_data, go_dat;
   logic [SEL_W-1:0] go_sel;

   pcb_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr),
      .wdata(host_wdata), .rdata(host_rdata), .busy(busy),
      .cap_en(cap_en), .cap_data(cap_data), .go_wr(go_wr), .go_rd(go_rd),
      .go_sel(go_sel), .go_rs(go_rs), .go_dat(go_dat)
   );

   pcb_seq #(.DW(DW), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .go_rd(go_rd),
      .go_sel(go_sel), .go_rs(go_rs), .go_dat(go_dat), .busy(busy),
      .cap_en(cap_en), .cap_data(cap_data), .cs_n(bus_cs_n),
      .wr_n(bus_wr_n), .rd_n(bus_rd_n), .rs(bus_rs), .dout(bus_dout),
      .oe(bus_oe), .din(bus_din)
   );
endmodule

// File: tb/panel_cmd_bridge_bench.sv
module panel_cmd_bridge_bench;
   localparam int L = 2;
   localparam int H = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  cs_n;
   logic        wr_n, rd_n, rs, oe;
   logic [15:0] dout;
   logic [15:0] din = '0;

   panel_cmd_bridge #(.DW(16), .LOW_CYC(L), .HIGH_CYC(H)) u_panel_cmd_bridge (
      .clk(clk), .rst_n(rst_n), .host_we(we), .host_addr(addr),
      .host_wdata(wdata), .host_rdata(rdata), .bus_cs_n(cs_n),
      .bus_wr_n(wr_n), .bus_rd_n(rd_n), .bus_rs(rs), .bus_dout(dout),
      .bus_oe(oe), .bus_din(din)
   );

   typedef struct packed {
      logic        rd;
      logic        sel;
      logic        rs;
      logic [15:0] dat;
   } item_t;

   item_t exp_q[$];
   int checks = 0, bad = 0, events = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_idle(output int n);
      logic [31:0] s;
      n = 0;
      for (int i = 0; i < 100; i++) begin
         reg_rd(3'd4, s);
         if (!s[1]) break;
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_write(input logic sel, input logic r, input logic [15:0] d);
      int n;
      reg_wr(3'd0, {3'b0, 1'b1, 3'b0, r, 8'h00, d});
      exp_q.push_back('{rd: 1'b0, sel: sel, rs: r, dat: d});
      reg_wr(3'd2, {30'b0, sel, 1'b1});
      wait_idle(n);
      chk(n == 1 + L + H, "R5 busy length", n, 1 + L + H);
   endtask

   task automatic do_read(input logic sel, input logic r, input logic [15:0] v);
      int n;
      logic [31:0] got;
      din = v;
      reg_wr(3'd1, {7'b0, r, 24'h0});
      exp_q.push_back('{rd: 1'b1, sel: sel, rs: r, dat: 16'h0});
      reg_wr(3'd3, {30'b0, sel, 1'b1});
      wait_idle(n);
      chk(n == 1 + L + H, "R5 busy length read", n, 1 + L + H);
      reg_rd(3'd1, got);
      chk(got == {7'b0, r, 8'h0, v}, "R7 read word", got, {7'b0, r, 8'h0, v});
   endtask

   // monitor / scoreboard
   logic was_lo = 1'b0, prev_act = 1'b0, post = 1'b0;
   int   lowcnt = 0, hcnt = 0;
   item_t cap;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!wr_n || !rd_n) begin
            if (!was_lo) begin
               chk(prev_act, "R8 cs setup before strobe", 0, 1);
               cap.rd  = !rd_n;
               cap.sel = !cs_n[1];
               cap.rs  = rs;
               cap.dat = dout;
               lowcnt  = 0;
               chk((cs_n == 2'b10) || (cs_n == 2'b01), "R11 single select", cs_n, 2'b10);
               chk(!(!wr_n && !rd_n), "R11 single strobe", {wr_n, rd_n}, 2'b10);
               if (!rd_n) chk(!oe, "R6 bus released", oe, 0);
               else chk(oe, "R2 bus driven", oe, 1);
            end
            if (rs != cap.rs) chk(0, "R8 rs stable", rs, cap.rs);
            lowcnt++;
            was_lo = 1'b1;
         end else if (was_lo) begin
            was_lo = 1'b0;
            events++;
            chk(lowcnt == L, "R8 low width", lowcnt, L);
            post = 1'b1;
            hcnt = 1;
            if (exp_q.size() == 0) chk(0, "R9 R10 unexpected cycle", 1, 0);
            else begin
               item_t e;
               e = exp_q.pop_front();
               if (!e.rd) chk(cap == e, "R2 R3 R4 write cycle", cap, e);
               else chk(cap[18:16] == e[18:16], "R6 R4 read cycle", cap[18:16], e[18:16]);
            end
         end else if (post) begin
            if (cs_n != 2'b11) hcnt++;
            else begin
               post = 1'b0;
               chk(hcnt == H, "R8 high hold", hcnt, H);
            end
         end
         prev_act = (cs_n != 2'b11);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] s;
      int n, ev0;
      repeat (3) @(negedge clk);
      reg_rd(3'd4, s);
      chk(cs_n == 2'b11 && wr_n && rd_n && !oe, "R1 bus idle in reset",
          {cs_n, wr_n, rd_n, oe}, 5'b11110);
      chk(s == 0, "R1 status in reset", s, 0);
      rst_n = 1'b1;
      @(negedge clk);
      reg_rd(3'd4, s);
      chk(s == 0 && cs_n == 2'b11, "R1 status after reset", s, 0);

      do_write(1'b0, 1'b0, 16'h0A5C);   // R2 index, main
      do_write(1'b1, 1'b1, 16'h1234);   // R3 data, sub
      do_write(1'b0, 1'b1, 16'hFFFF);   // R3 data, main
      do_write(1'b1, 1'b0, 16'h0001);   // R2 index, sub
      do_read(1'b0, 1'b1, 16'hBEEF);    // R6 R7 main
      do_read(1'b1, 1'b0, 16'h5A0F);    // R6 R7 sub

      // R4: trigger bit 0 clear launches nothing
      ev0 = events;
      reg_wr(3'd2, 32'h2);
      reg_wr(3'd3, 32'h2);
      repeat (10) @(negedge clk);
      reg_rd(3'd4, s);
      chk(events == ev0 && s == 0 && cs_n == 2'b11, "R4 no go bit", events, ev0);

      // R10: command word without cycle mark
      reg_wr(3'd0, 32'h0100_1111);
      reg_wr(3'd2, 32'h1);
      repeat (10) @(negedge clk);
      chk(events == ev0 && cs_n == 2'b11, "R10 unmarked word", events, ev0);

      // R9: triggers during busy are dropped
      reg_wr(3'd0, 32'h1100_3C3C);
      exp_q.push_back('{rd: 1'b0, sel: 1'b0, rs: 1'b1, dat: 16'h3C3C});
      reg_wr(3'd2, 32'h1);
      we = 1'b1; addr = 3'd2; wdata = 32'h3;
      @(negedge clk);
      addr = 3'd3; wdata = 32'h1;
      @(negedge clk);
      we = 1'b0;
      wait_idle(n);
      repeat (10) @(negedge clk);
      chk(events == ev0 + 1, "R9 single cycle while busy", events, ev0 + 1);
      chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
      summary();
   end
endmodule